// File: doc/BRIEF.md
# Two-Symbol Command Output Latch

This block holds a single output level and lets a stream of two-bit input symbols edit it. Each accepted symbol is paired with the symbol accepted before it, and three specific pairs act as commands. One pair clears the level, one sets it, and one inverts it. Every other pair leaves the level as it was. The block is a Mealy machine. The edited level shows on the output in the same cycle as the second symbol of a command. It is also registered at the next clock edge, so it stays in place until another command completes.

A symbol is accepted only in a cycle where the valid strobe is high. Cycles with the strobe low neither move the level nor replace the remembered symbol, so a command may be split by idle cycles. Commands may overlap: the second symbol of one command can open the next. A synchronous reset clears the level and discards the remembered symbol.

Top module: `seq_cmd_latch`

## Requirements
- R1: While reset is high at a clock edge, the level is cleared to 0 and the remembered symbol is discarded. A command second symbol accepted first after reset therefore completes no command. For example, 10, then reset, then 11 leaves the level at 0.
- R2: Symbol {x1,x2}=01 accepted and then symbol 11 accepted forces the level to 0.
- R3: Symbol 10 accepted and then symbol 11 accepted forces the level to 1.
- R4: Symbol 10 accepted and then symbol 01 accepted inverts the level.
- R5: The new level appears on `z_out` during the cycle in which the second symbol is presented with the strobe high, before the clock edge that accepts it.
- R6: After the accepting edge, the updated level persists on `z_out` in later cycles in which no command completes.
- R7: Commands overlap. In the sequence 10, 01, 11, the level is inverted at 01 and then cleared at 11.
- R8: Any accepted pair other than the three commands leaves the level unchanged. Examples are 00 followed by any symbol, 11 followed by 11, 01 followed by 01, and 10 followed by 10.
- R9: In a cycle with `sym_valid` low, `z_out` equals the held level whatever the symbol inputs carry, and the remembered symbol is kept. As a result, 10, then an idle cycle carrying 01, then 11 still sets the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Strobe: the symbol on sym_x1/sym_x2 is accepted this cycle |
| sym_x1 | input | 1 | First bit of the input symbol |
| sym_x2 | input | 1 | Second bit of the input symbol |
| z_out | output | 1 | Level output (Mealy: shows a command's result in the same cycle) |

## Verification
The hardest condition to bring about is a command whose two symbols are separated by idle cycles. In those cycles the symbol inputs carry a value that would complete a different command if the strobe were high. The stimulus presents 10, then an idle cycle carrying 01, then 11. It expects a set and no inversion. A related case uses a reset between the two symbols of a set command, which shows that the remembered symbol is dropped. Overlapping chains are driven back to back from both starting levels. This shows that the second symbol of one command opens the next.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
   localparam int SYM_W = 2;
   typedef logic [SYM_W-1:0] sym_t;
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_CLR  = 2'd1,
      CMD_SET  = 2'd2,
      CMD_INV  = 2'd3
   } cmd_e;
endpackage

// File: rtl/seq_cmd_hist.sv
module seq_cmd_hist
   import seq_cmd_pkg::*;
#(
   parameter sym_t IDLE_SYM = '0
) (
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  sym_t sym_in,
   output sym_t sym_prev
);
   always_ff @(posedge clk) begin
      if (rst)
         sym_prev <= IDLE_SYM;
      else if (take)
         sym_prev <= sym_in;
   end
endmodule

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
   import seq_cmd_pkg::*;
#(
   parameter sym_t CLR_OPEN  = 2'b01,
   parameter sym_t SET_OPEN  = 2'b10,
   parameter sym_t CLOSE_SYM = 2'b11,
   parameter sym_t INV_CLOSE = 2'b01
) (
   input  sym_t sym_prev,
   input  sym_t sym_cur,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NONE;
      if (sym_prev == CLR_OPEN && sym_cur == CLOSE_SYM)
         cmd = CMD_CLR;
      else if (sym_prev == SET_OPEN && sym_cur == CLOSE_SYM)
         cmd = CMD_SET;
      else if (sym_prev == SET_OPEN && sym_cur == INV_CLOSE)
         cmd = CMD_INV;
   end
endmodule

// File: rtl/seq_cmd_level.sv
module seq_cmd_level
   import seq_cmd_pkg::*;
#(
   parameter logic RST_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  cmd_e cmd,
   output logic level_nxt,
   output logic level_q
);
   always_comb begin
      level_nxt = level_q;
      if (take) begin
         unique case (cmd)
            CMD_CLR:  level_nxt = 1'b0;
            CMD_SET:  level_nxt = 1'b1;
            CMD_INV:  level_nxt = ~level_q;
            default:  level_nxt = level_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         level_q <= RST_LEVEL;
      else
         level_q <= level_nxt;
   end
endmodule

// File: rtl/seq_cmd_latch.sv
module seq_cmd_latch
   import seq_cmd_pkg::*;
#(
   parameter sym_t CLR_OPEN  = 2'b01,
   parameter sym_t SET_OPEN  = 2'b10,
   parameter sym_t CLOSE_SYM = 2'b11,
   parameter sym_t INV_CLOSE = 2'b01,
   parameter sym_t IDLE_SYM  = 2'b00
) (
   input  logic clk,
   input  logic rst,
   input  logic sym_valid,
   input  logic sym_x1,
   input  logic sym_x2,
   output logic z_out
);
   localparam logic RST_LEVEL = 1'b0;

   // elaboration-time parameter checks
   if (CLR_OPEN == SET_OPEN) begin : g_bad_open
      $error("seq_cmd_latch: clear and set opening symbols must differ");
   end
   if (CLOSE_SYM == INV_CLOSE) begin : g_bad_close
      $error("seq_cmd_latch: set close and invert close must differ");
   end
   if (IDLE_SYM == CLR_OPEN || IDLE_SYM == SET_OPEN) begin : g_bad_idle
      $error("seq_cmd_latch: idle symbol must open no command");
   end

   sym_t sym_cur;
   sym_t sym_prev;
   cmd_e cmd;
   logic level_nxt;
   logic level_q;

   assign sym_cur = {sym_x1, sym_x2};

   seq_cmd_hist #(.IDLE_SYM(IDLE_SYM)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .take     (sym_valid),
      .sym_in   (sym_cur),
      .sym_prev (sym_prev)
   );

   seq_cmd_decode #(
      .CLR_OPEN  (CLR_OPEN),
      .SET_OPEN  (SET_OPEN),
      .CLOSE_SYM (CLOSE_SYM),
      .INV_CLOSE (INV_CLOSE)
   ) u_dec (
      .sym_prev (sym_prev),
      .sym_cur  (sym_cur),
      .cmd      (cmd)
   );

   seq_cmd_level #(.RST_LEVEL(RST_LEVEL)) u_lvl (
      .clk       (clk),
      .rst       (rst),
      .take      (sym_valid),
      .cmd       (cmd),
      .level_nxt (level_nxt),
      .level_q   (level_q)
   );

   assign z_out = level_nxt;
endmodule

// File: rtl/seq_cmd_latch_chk.sv
module seq_cmd_latch_chk (
   input logic clk,
   input logic rst,
   input logic sym_valid,
   input logic sym_x1,
   input logic sym_x2,
   input logic z_out,
   input logic level_q
);
   logic [1:0] seen_sym;
   logic       held_z;
   logic [1:0] now_sym;

   assign now_sym = {sym_x1, sym_x2};

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_sym <= 2'b00;
         held_z   <= 1'b0;
      end else begin
         if (sym_valid) seen_sym <= now_sym;
         held_z <= z_out;
      end
   end

   // R1: a reset edge leaves the stored level at 0
   a_r1_reset_clears: assert property (@(posedge clk) rst |=> level_q == 1'b0);

   // R2
   a_r2_clear_cmd: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && seen_sym == 2'b01 && now_sym == 2'b11) |-> z_out == 1'b0);

   // R3
   a_r3_set_cmd: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && seen_sym == 2'b10 && now_sym == 2'b11) |-> z_out == 1'b1);

   // R4
   a_r4_invert_cmd: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && seen_sym == 2'b10 && now_sym == 2'b01) |-> z_out == ~held_z);

   // R6: accepted value is the registered level on the next cycle
   a_r6_level_persists: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> level_q == $past(z_out));

   // R8
   a_r8_other_pairs_hold: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && !(seen_sym == 2'b01 && now_sym == 2'b11)
                 && !(seen_sym == 2'b10 && now_sym == 2'b11)
                 && !(seen_sym == 2'b10 && now_sym == 2'b01)) |-> z_out == held_z);

   // R9
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |-> z_out == held_z);
endmodule

bind seq_cmd_latch seq_cmd_latch_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .sym_valid (sym_valid),
   .sym_x1    (sym_x1),
   .sym_x2    (sym_x2),
   .z_out     (z_out),
   .level_q   (level_q)
);

// File: tb/sim_seq_cmd_latch.sv
module sim_seq_cmd_latch;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sym_valid = 1'b0;
   logic sym_x1 = 1'b0;
   logic sym_x2 = 1'b0;
   logic z_out;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   // reference model state, derived from the requirements
   logic       m_z = 1'b0;
   logic [1:0] m_prev = 2'b00;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   seq_cmd_latch u0 (
      .clk       (clk),
      .rst       (rst),
      .sym_valid (sym_valid),
      .sym_x1    (sym_x1),
      .sym_x2    (sym_x2),
      .z_out     (z_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: z_out actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // present one symbol, check the Mealy output before the edge, then clock it
   task automatic send(input string req, input logic [1:0] s, input logic v);
      logic nz;
      @(negedge clk);
      sym_valid = v;
      {sym_x1, sym_x2} = s;
      #1;
      nz = m_z;
      if (v) begin
         if (m_prev == 2'b01 && s == 2'b11) nz = 1'b0;
         else if (m_prev == 2'b10 && s == 2'b11) nz = 1'b1;
         else if (m_prev == 2'b10 && s == 2'b01) nz = ~m_z;
      end
      check(req, z_out, nz);
      @(posedge clk);
      m_z = nz;
      if (v) m_prev = s;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      sym_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_z = 1'b0;
      m_prev = 2'b00;
   endtask

   task automatic t_reset_state();
      do_reset();
      #1;
      check("R1 reset level", z_out, 1'b0);
   endtask

   task automatic t_set();
      send("R3 open", 2'b10, 1'b1);
      send("R3 R5 set same cycle", 2'b11, 1'b1);
      check("R3 model", m_z, 1'b1);
      send("R6 persists", 2'b00, 1'b0);
      send("R6 persists again", 2'b00, 1'b1);
   endtask

   task automatic t_clear();
      send("R2 open", 2'b01, 1'b1);
      send("R2 R5 clear same cycle", 2'b11, 1'b1);
      check("R2 model", m_z, 1'b0);
      send("R6 stays clear", 2'b11, 1'b0);
   endtask

   task automatic t_invert();
      send("R4 open", 2'b10, 1'b1);
      send("R4 invert from 0", 2'b01, 1'b1);
      send("R4 open again", 2'b10, 1'b1);
      send("R4 invert from 1", 2'b01, 1'b1);
      check("R4 model", m_z, 1'b0);
   endtask

   task automatic t_overlap();
      send("R7 open", 2'b10, 1'b1);
      send("R7 invert", 2'b01, 1'b1);
      send("R7 then clear", 2'b11, 1'b1);
      // from level 1: set, then chain 10,01,11
      send("R7 prep", 2'b10, 1'b1);
      send("R7 prep set", 2'b11, 1'b1);
      send("R7 open2", 2'b10, 1'b1);
      send("R7 invert to 0", 2'b01, 1'b1);
      send("R7 clear", 2'b11, 1'b1);
   endtask

   task automatic t_other_pairs();
      // level 0 then level 1
      for (int lv = 0; lv < 2; lv++) begin
         if (lv == 1) begin
            send("R8 prep", 2'b10, 1'b1);
            send("R8 prep set", 2'b11, 1'b1);
         end
         send("R8 00", 2'b00, 1'b1);
         send("R8 00->11", 2'b11, 1'b1);
         send("R8 11->11", 2'b11, 1'b1);
         send("R8 11->01", 2'b01, 1'b1);
         send("R8 01->01", 2'b01, 1'b1);
         send("R8 01->10", 2'b10, 1'b1);
         send("R8 10->10", 2'b10, 1'b1);
         send("R8 10->00", 2'b00, 1'b1);
      end
   endtask

   task automatic t_idle_gap();
      do_reset();
      send("R9 open", 2'b10, 1'b1);
      send("R9 idle carrying 01", 2'b01, 1'b0);
      send("R9 idle carrying 11", 2'b11, 1'b0);
      send("R9 close sets", 2'b11, 1'b1);
      check("R9 model set", m_z, 1'b1);
      send("R9 open clr", 2'b01, 1'b1);
      send("R9 idle carrying 11 no clear", 2'b11, 1'b0);
      send("R9 still held", 2'b10, 1'b0);
      send("R9 close clears", 2'b11, 1'b1);
   endtask

   task automatic t_reset_forgets();
      send("R1 prep", 2'b10, 1'b1);
      do_reset();
      #1;
      check("R1 cleared", z_out, 1'b0);
      send("R1 close after reset no set", 2'b11, 1'b1);
      check("R1 model", m_z, 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_set();
      t_clear();
      t_invert();
      t_overlap();
      t_other_pairs();
      t_idle_gap();
      t_reset_forgets();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule